// File: doc/BRIEF.md
# Quarter-Rate Quadrature Mixer

This block turns a real sample stream into in-phase and quadrature streams by mixing it with a complex local oscillator that runs at exactly one quarter of the sample rate. The oscillator only ever takes the values +1, 0 and -1, so the mixer has no multiplier. Each accepted sample is passed through, negated, or replaced by zero on each of the two branches, depending on the oscillator phase.

The default translation is a negative quarter-rate shift. It moves the upper sideband of the real input down to DC. A sideband select input reverses the direction and brings the lower sideband to DC instead. A sync input forces the oscillator to its zero-degree phase for the sample that comes with it, so a following decimate-by-two filter sees a known alignment. Each accepted sample carries a nonzero value on only one branch. The block raises a strobe for that branch, so each branch's strobe fires on every second accepted sample. This gives the half-rate streams the downstream filter consumes.

Top module: `hbdc_quarter_mixer`

## Requirements
- R1: After reset, both data outputs are 0 and both strobes are low until the first accepted sample.
- R2: A sample is accepted on a clock edge where `in_valid` is high. Its result appears on the outputs one clock later. The result comes with `i_valid` when the oscillator phase is even (0 or 2) and with `q_valid` when the phase is odd (1 or 3).
- R3: With `lsb_sel` low, phases 0, 1, 2 and 3 produce (I, Q) = (x, 0), (0, -x), (-x, 0) and (0, x). This is x multiplied by exp(-j*pi*n/2).
- R4: With `lsb_sel` high, the Q value is negated relative to R3: phase 1 gives (0, x) and phase 3 gives (0, -x). I is unchanged.
- R5: The phase advances by one, modulo 4, on every accepted sample. An accepted sample with `in_sync` high is mixed at phase 0, and the next accepted sample uses phase 1.
- R6: Negating the most negative value -32768 gives +32767 instead of wrapping.
- R7: A cycle with `in_valid` low leaves both data outputs unchanged and both strobes low. It does not advance the phase. `in_sync` has no effect on such a cycle.
- R8: At most one strobe is high in any cycle. The branch without a strobe carries 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_sample` as a sample to accept |
| in_sample | input | 16 | Real input, two's complement |
| in_sync | input | 1 | Forces phase 0 for the sample accepted with it |
| lsb_sel | input | 1 | 0: upper sideband to DC, 1: lower sideband to DC |
| i_valid | output | 1 | In-phase result strobe |
| i_data | output | 16 | In-phase result |
| q_valid | output | 1 | Quadrature result strobe |
| q_data | output | 16 | Quadrature result |

## Verification
The assertions assume the inputs are driven to known values at every clock edge after reset. They also assume `in_sync` and `lsb_sel` matter only on edges where `in_valid` is high. The stimulus changes inputs only between edges, and never leaves any input at X. It makes gapped streams with idle cycles, and raises sync both on idle cycles and in the middle of the phase sequence. The value -32768 is placed at every phase under both sidebands, so each negation path meets the saturation case.

// File: rtl/hbdc_pkg.sv
// Package: shared types for the quarter-rate mixer.
// Assumes a 2-bit oscillator phase; 90-degree steps wrap modulo 4.
package hbdc_pkg;
    localparam int unsigned PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_0   = 2'd0,
        PH_90  = 2'd1,
        PH_180 = 2'd2,
        PH_270 = 2'd3
    } lo_phase_t;
endpackage

// File: rtl/hbdc_phase_gen.sv
// Module: oscillator phase generator.
// Provides the phase to use for the current sample and advances by one
// step per accepted sample. A sync on an accepted sample forces phase 0.
// Assumes sync is only meaningful together with adv.
module hbdc_phase_gen
    import hbdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      sync,
    output lo_phase_t cur_phase
);
    lo_phase_t phase_q;

    // Effective phase for this sample: sync overrides the stored phase.
    always_comb begin
        cur_phase = (adv && sync) ? PH_0 : phase_q;
    end

    // Stored phase: step past the effective phase on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_0;
        end else if (adv) begin
            phase_q <= lo_phase_t'(cur_phase + 2'd1);
        end
    end
endmodule

// File: rtl/hbdc_mixer.sv
// Module: multiplier-free quarter-rate mixer (combinational).
// Chooses pass, negate or zero for each branch, based on the phase.
// Negation saturates the most negative code to the largest positive one.
// Assumes two's complement input of width W.
module hbdc_mixer
    import hbdc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] sample,
    input  lo_phase_t    phase,
    input  logic         lsb_sel,
    output logic [W-1:0] i_mix,
    output logic [W-1:0] q_mix,
    output logic         odd_phase
);
    localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] neg_sample;
    logic         q_negate;

    // Saturating negation of the input sample.
    always_comb begin
        neg_sample = (sample == MIN_CODE) ? MAX_CODE : (~sample + 1'b1);
    end

    // Branch selection per phase; the sideband select flips the Q sign.
    always_comb begin
        odd_phase = phase[0];
        q_negate  = (phase == PH_90) ^ lsb_sel;
        i_mix     = '0;
        q_mix     = '0;
        unique case (phase)
            PH_0:    i_mix = sample;
            PH_180:  i_mix = neg_sample;
            PH_90,
            PH_270:  q_mix = q_negate ? neg_sample : sample;
            default: i_mix = '0;
        endcase
    end
endmodule

// File: rtl/hbdc_quarter_mixer.sv
// Module: top of the quarter-rate quadrature down-converter.
// Accepts one real sample per valid cycle. It registers the mixed I/Q
// values and a strobe for the branch that carries the nonzero term.
// Latency is one clock. Assumes inputs are synchronous to clk.
module hbdc_quarter_mixer
    import hbdc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_sample,
    input  logic         in_sync,
    input  logic         lsb_sel,
    output logic         i_valid,
    output logic [W-1:0] i_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);
    lo_phase_t    cur_phase;
    logic [W-1:0] i_mix;
    logic [W-1:0] q_mix;
    logic         odd_phase;

    hbdc_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (in_valid),
        .sync      (in_sync),
        .cur_phase (cur_phase)
    );

    hbdc_mixer #(.W(W)) u_mix (
        .sample    (in_sample),
        .phase     (cur_phase),
        .lsb_sel   (lsb_sel),
        .i_mix     (i_mix),
        .q_mix     (q_mix),
        .odd_phase (odd_phase)
    );

    // Output stage: capture the mix on accepted samples, strobe one branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_valid <= 1'b0;
            q_valid <= 1'b0;
            i_data  <= '0;
            q_data  <= '0;
        end else begin
            i_valid <= in_valid && !odd_phase;
            q_valid <= in_valid && odd_phase;
            if (in_valid) begin
                i_data <= i_mix;
                q_data <= q_mix;
            end
        end
    end
endmodule

// File: rtl/hbdc_quarter_mixer_chk.sv
// Module: protocol checker for the quarter-rate mixer, bound to the top.
// Assumes inputs are known at each clock edge after reset.
module hbdc_quarter_mixer_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_sample,
    input logic         in_sync,
    input logic         lsb_sel,
    input logic         i_valid,
    input logic [W-1:0] i_data,
    input logic         q_valid,
    input logic [W-1:0] q_data
);
    localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

    // R8: never both strobes
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_valid, q_valid}));

    // R8: unstrobed branch is zero
    assert_idle_branch_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid |-> q_data == '0) and (q_valid |-> i_data == '0));

    // R2: each accepted sample yields exactly one strobe a cycle later
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (i_valid || q_valid));

    // R7: no strobe and held data without an accepted sample
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!i_valid && !q_valid && $stable(i_data) && $stable(q_data)));

    // R5: sync sample lands on phase 0, an I result
    assert_sync_phase0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync) |=> i_valid);

    // R5: without sync, branches alternate between successive accepted samples
    assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && in_valid && !in_sync) |=> i_valid);
    assert_alternate_i_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && in_valid && !in_sync) |=> q_valid);

    // R6: the most negative code on a sync sample passes through on I unchanged
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync && in_sample == MIN_CODE) |=> i_data == MIN_CODE);

    // R3: sync sample is passed to I unmodified
    assert_phase0_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync) |=> i_data == $past(in_sample));

    // R4: sideband select never disturbs the sign of a phase 0 I result
    assert_lsb_keeps_i_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync && lsb_sel) |=> (i_data == $past(in_sample) && q_data == '0));
endmodule

bind hbdc_quarter_mixer hbdc_quarter_mixer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .in_sync   (in_sync),
    .lsb_sel   (lsb_sel),
    .i_valid   (i_valid),
    .i_data    (i_data),
    .q_valid   (q_valid),
    .q_data    (q_data)
);

// File: tb/tb_hbdc_quarter_mixer.sv
// Scoreboard bench: the driver predicts each result and queues it; the
// monitor pops and compares whenever a strobe appears.
module tb_hbdc_quarter_mixer;
    localparam int W = 16;
    localparam logic [W-1:0] MINV = 16'h8000;
    localparam logic [W-1:0] MAXV = 16'h7FFF;

    typedef struct {
        logic         is_q;
        logic [W-1:0] i_exp;
        logic [W-1:0] q_exp;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic         in_sync = 1'b0;
    logic         lsb_sel = 1'b0;
    logic         i_valid, q_valid;
    logic [W-1:0] i_data, q_data;

    int     checks = 0;
    int     fails = 0;
    bit     mon_on = 1'b0;
    bit     done = 1'b0;
    int     model_ph = 0;
    item_t  sb_q[$];
    logic [W-1:0] last_i = '0, last_q = '0;

    always #10 clk = ~clk;

    hbdc_quarter_mixer #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_sync(in_sync), .lsb_sel(lsb_sel), .i_valid(i_valid), .i_data(i_data),
        .q_valid(q_valid), .q_data(q_data)
    );

    function automatic logic [W-1:0] neg_clip(input logic [W-1:0] v);
        return (v == MINV) ? MAXV : W'(-$signed(v));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: present one accepted sample and queue the predicted result.
    task automatic drive(input logic [W-1:0] x, input bit sy, input bit sb, input string req);
        item_t it;
        int ph;
        @(negedge clk);
        in_valid = 1'b1; in_sample = x; in_sync = sy; lsb_sel = sb;
        ph = sy ? 0 : model_ph;
        it.req = req;
        it.is_q = ph[0];
        it.i_exp = '0; it.q_exp = '0;
        case (ph)
            0: it.i_exp = x;
            1: it.q_exp = sb ? x : neg_clip(x);
            2: it.i_exp = neg_clip(x);
            default: it.q_exp = sb ? neg_clip(x) : x;
        endcase
        model_ph = (ph + 1) % 4;
        sb_q.push_back(it);
    endtask

    task automatic idle(input bit sy);
        @(negedge clk);
        in_valid = 1'b0; in_sync = sy; in_sample = 16'hDEAD; lsb_sel = ~lsb_sel;
    endtask

    // Monitor: compare strobed results; check holding on quiet cycles.
    always @(negedge clk) begin
        if (mon_on) begin
            if (i_valid || q_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected strobe", {15'd0, q_valid}, '0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(q_valid == it.is_q && i_valid == !it.is_q, "R2",
                          "strobe branch", {15'd0, q_valid}, {15'd0, it.is_q});
                    check(i_data == it.i_exp, it.req, "i_data", i_data, it.i_exp);
                    check(q_data == it.q_exp, it.req, "q_data", q_data, it.q_exp);
                end
            end else begin
                check(i_data == last_i && q_data == last_q, "R7", "data hold",
                      i_data, last_i);
            end
            last_i = i_data;
            last_q = q_data;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(i_data == '0 && q_data == '0, "R1", "reset data", i_data, '0);
        check(!i_valid && !q_valid, "R1", "reset strobes", {14'd0, i_valid, q_valid}, '0);
        mon_on = 1'b1;

        // R3: upper sideband, full phase cycle twice
        for (int k = 0; k < 8; k++) drive(W'(100 + 7 * k), 1'b0, 1'b0, "R3");
        // R4: lower sideband
        for (int k = 0; k < 8; k++) drive(W'(-300 + 50 * k), 1'b0, 1'b1, "R4");
        // R5: sync at phase 2 restarts from 0
        drive(16'd11, 1'b0, 1'b0, "R3");
        drive(16'd22, 1'b0, 1'b0, "R3");
        drive(16'd33, 1'b1, 1'b0, "R5");
        drive(16'd44, 1'b0, 1'b0, "R5");
        // R7: idle cycles with sync raised, phase must hold
        idle(1'b1); idle(1'b1); idle(1'b0);
        drive(16'd55, 1'b0, 1'b0, "R7");
        drive(16'd66, 1'b0, 1'b1, "R7");
        // R6: most negative value at every phase, both sidebands
        drive(16'd1, 1'b1, 1'b0, "R5");
        for (int k = 0; k < 4; k++) drive(MINV, 1'b0, 1'b0, "R6");
        for (int k = 0; k < 4; k++) drive(MINV, 1'b0, 1'b1, "R6");
        for (int k = 0; k < 4; k++) drive(MAXV, 1'b0, 1'b0, "R6");
        // Gapped pseudo-random stream covering R3, R4, R5, R7
        lfsr = 16'hACE1;
        for (int k = 0; k < 120; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) idle(lfsr[3]);
            else drive(lfsr, lfsr[11:8] == 4'd0, lfsr[5], "R8");
        end
        idle(1'b0); idle(1'b0); idle(1'b0);
        @(negedge clk);
        check(sb_q.size() == 0, "R2", "results outstanding", W'(sb_q.size()), '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule